// File: doc/BRIEF.md
# Pseudo-Ternary Basic-Rate Frame Codec

This block moves two 64 kbit/s bearer channels and one 16 kbit/s signalling channel across a three-level line. It works in 48-bit frames, one bit per clock cycle. At the line rate of 192 kbit/s that is 4000 frames per second. On the transmit side, the block takes a new set of bearer octets and signalling bits at the start of every frame. It places them at fixed slots, adds balance bits that keep each group of slots free of DC, and codes every bit as a line symbol. A binary one is sent as the zero level. A binary zero is sent as a mark whose polarity is the opposite of the previous mark. The one exception is the frame-start slot, which repeats the polarity of the previous mark on purpose so that the frame boundary can be found.

The receive side decodes incoming symbols and looks for that deliberate polarity violation. It counts consecutive violations that arrive exactly one frame apart before it declares lock. It holds lock through a single missing violation. Once locked, it delivers the bearer and signalling bits of each frame as a one-cycle strobe. While locked, it also retimes the transmitter so that outgoing frames start two bit periods after incoming ones.

Top module: `bri_ternary_codec`

## Requirements
- R1: Line symbols are two bits wide: 2'b00 is the zero level, 2'b01 is +1 and 2'b11 is -1. The transmitter never emits 2'b10.
- R2: Outside the frame-start slot, a binary one is sent as 2'b00, and a binary zero is sent as a mark of the opposite polarity to the previous transmitted mark.
- R3: Slot 0 of every transmitted frame is a mark with the same polarity as the previous mark. After reset the previous polarity counts as -1, so the first frame starts with 2'b11. `txFrameMark` is high exactly while slot 0 is on `txSym`.
- R4: Frame slots are assigned as follows:
  - slot 0: frame start
  - slots 1, 10, 21, 32, 43 and 45: balance bits
  - bearer 1: bits 15..8 in slots 2..9 and bits 7..0 in slots 24..31
  - bearer 2: bits 15..8 in slots 13..20 and bits 7..0 in slots 35..42
  - signalling bits 0..3: slots 11, 22, 33 and 44
  - slots 12, 23, 34, 46 and 47: maintenance slots, always binary one
  - within each octet run, the most significant bit goes first
- R5: Each balance bit is a zero (a mark) exactly when the slots since the previous balance bit, or since the frame start, hold an odd number of marks. Every group, balance bit included, therefore carries an even number of marks.
- R6: The transmit inputs are sampled once per frame, in the cycle before slot 0 appears on `txSym`. Changes made after that cycle affect only the next frame.
- R7: A violation is a received mark with the same polarity as the previous received mark. `rxLock` rises the cycle after the third of three violations that are each 48 symbols apart. If the expected violation is absent before lock, the count restarts.
- R8: While locked, a single missing violation at the frame-start slot keeps the lock. A second consecutive miss clears `rxLock` in the cycle after that slot.
- R9: While locked, `rxValid` pulses for one cycle after slot 47 of each frame is received. With it, `rxB1`, `rxB2` and `rxD` carry that frame's bits in the R4 layout, with a mark decoded as 0 and the zero level decoded as 1.
- R10: A received 2'b10 raises `rxErr` for exactly the following cycle.
- R11: While locked, each received frame-start violation retimes the transmitter so that its slot 0 appears on `txSym` two cycles after the violation symbol was presented on `rxSym`.
- R12: During reset, `txSym` is 2'b00 and `txFrameMark`, `rxLock`, `rxValid` and `rxErr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one symbol per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| txB1 | input | 16 | Bearer 1 bits for the next frame |
| txB2 | input | 16 | Bearer 2 bits for the next frame |
| txD | input | 4 | Signalling bits for the next frame |
| txSym | output | 2 | Transmitted line symbol |
| txFrameMark | output | 1 | High while the frame-start symbol is on txSym |
| rxSym | input | 2 | Received line symbol |
| rxB1 | output | 16 | Received bearer 1 bits |
| rxB2 | output | 16 | Received bearer 2 bits |
| rxD | output | 4 | Received signalling bits |
| rxValid | output | 1 | One-cycle strobe at the end of each locked frame |
| rxLock | output | 1 | Receiver has frame alignment |
| rxErr | output | 1 | Previous received symbol was the illegal code |

## Verification
The assertions assume that `rxSym` carries one legal code per cycle apart from deliberate 2'b10 probes. They also assume that the far end produces the alternating-mark pattern with a single violation per frame, so that lock is only ever reached on a frame-start mark. The stimulus keeps to these assumptions: every received frame comes from an independent bench encoder of the R4 and R5 layout, and a single opening mark sets the received polarity history before the first violation. Frames are sent as whole frames or as full idle frames of zero-level symbols, so a missing violation never leaves a stray mark in the pattern.

// File: rtl/bri_pkg.sv
package bri_pkg;
  localparam int FRAME_BITS = 48;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int B_BITS     = 16;
  localparam int D_BITS     = 4;
  localparam int IDX_W      = $clog2(B_BITS);

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;
  localparam logic [1:0] SYM_BAD  = 2'b10;

  typedef enum logic [2:0] {
    SLOT_FRAME, SLOT_BAL, SLOT_B1, SLOT_B2, SLOT_D, SLOT_AUX
  } slotKind_t;

  typedef struct packed {
    slotKind_t        kind;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic txFrame;    // transmit position is the frame-start slot
    logic rxDeliver;  // last slot of a locked receive frame
  } strobe_t;

  // Computed slot map of the 48-bit frame
  function automatic slot_t slotOf(input logic [POS_W-1:0] pos);
    slot_t s;
    s.kind = SLOT_AUX;
    s.idx  = '0;
    if (pos == 6'd0) begin
      s.kind = SLOT_FRAME;
    end else if (pos == 6'd1 || pos == 6'd10 || pos == 6'd21 ||
                 pos == 6'd32 || pos == 6'd43 || pos == 6'd45) begin
      s.kind = SLOT_BAL;
    end else if (pos >= 6'd2 && pos <= 6'd9) begin
      s.kind = SLOT_B1;
      s.idx  = IDX_W'(6'd17 - pos);
    end else if (pos >= 6'd24 && pos <= 6'd31) begin
      s.kind = SLOT_B1;
      s.idx  = IDX_W'(6'd31 - pos);
    end else if (pos >= 6'd13 && pos <= 6'd20) begin
      s.kind = SLOT_B2;
      s.idx  = IDX_W'(6'd28 - pos);
    end else if (pos >= 6'd35 && pos <= 6'd42) begin
      s.kind = SLOT_B2;
      s.idx  = IDX_W'(6'd42 - pos);
    end else if (pos == 6'd11) begin
      s.kind = SLOT_D;
      s.idx  = IDX_W'(0);
    end else if (pos == 6'd22) begin
      s.kind = SLOT_D;
      s.idx  = IDX_W'(1);
    end else if (pos == 6'd33) begin
      s.kind = SLOT_D;
      s.idx  = IDX_W'(2);
    end else if (pos == 6'd44) begin
      s.kind = SLOT_D;
      s.idx  = IDX_W'(3);
    end
    return s;
  endfunction
endpackage

// File: rtl/bri_codec_ctrl.sv
module bri_codec_ctrl
  import bri_pkg::*;
#(
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 2,
  parameter int TX_OFFSET   = 2   // legal range 2..FRAME_BITS+1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxViol,
  output logic [POS_W-1:0] txPos,
  output logic [POS_W-1:0] rxPos,
  output strobe_t          strobes,
  output logic             rxLock
);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(LOSS_MISSES + 1);
  localparam int ALIGN_LOAD = (FRAME_BITS + 2 - TX_OFFSET) % FRAME_BITS;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_LOCKED} lockState_t;

  lockState_t        state;
  logic [HIT_W-1:0]  hitCnt;
  logic [MISS_W-1:0] missCnt;
  logic              atStart;
  logic              lastHit;
  logic              frameHit;
  logic [POS_W-1:0]  rxPosNext;
  logic [POS_W-1:0]  txPosNext;

  always_comb begin
    atStart   = (rxPos == '0);
    lastHit   = (hitCnt == HIT_W'(LOCK_HITS - 1));
    frameHit  = atStart && rxViol &&
                ((state == ST_LOCKED) || (state == ST_CONFIRM && lastHit));
    rxPosNext = (rxPos == LAST_POS) ? '0 : rxPos + 1'b1;
    txPosNext = (txPos == LAST_POS) ? '0 : txPos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txPos <= '0;
    end else if (frameHit) begin
      txPos <= POS_W'(ALIGN_LOAD);
    end else begin
      txPos <= txPosNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      rxPos   <= '0;
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      rxPos <= rxPosNext;
      unique case (state)
        ST_HUNT: begin
          if (rxViol) begin
            state  <= ST_CONFIRM;
            rxPos  <= POS_W'(1);
            hitCnt <= HIT_W'(1);
          end
        end
        ST_CONFIRM: begin
          if (atStart) begin
            if (!rxViol) begin
              state <= ST_HUNT;
            end else if (lastHit) begin
              state   <= ST_LOCKED;
              missCnt <= '0;
            end else begin
              hitCnt <= hitCnt + 1'b1;
            end
          end else if (rxViol) begin
            rxPos  <= POS_W'(1);
            hitCnt <= HIT_W'(1);
          end
        end
        ST_LOCKED: begin
          if (atStart) begin
            if (rxViol) begin
              missCnt <= '0;
            end else if (missCnt == MISS_W'(LOSS_MISSES - 1)) begin
              state <= ST_HUNT;
            end else begin
              missCnt <= missCnt + 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    rxLock            = (state == ST_LOCKED);
    strobes.txFrame   = (txPos == '0);
    strobes.rxDeliver = (state == ST_LOCKED) && (rxPos == LAST_POS);
  end
endmodule

// File: rtl/bri_codec_dp.sv
module bri_codec_dp
  import bri_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [B_BITS-1:0] txB1,
  input  logic [B_BITS-1:0] txB2,
  input  logic [D_BITS-1:0] txD,
  input  logic [POS_W-1:0]  txPos,
  input  logic [POS_W-1:0]  rxPos,
  input  strobe_t           strobes,
  input  logic [1:0]        rxSym,
  output logic              rxViol,
  output logic [1:0]        txSym,
  output logic              txFrameMark,
  output logic [B_BITS-1:0] rxB1,
  output logic [B_BITS-1:0] rxB2,
  output logic [D_BITS-1:0] rxD,
  output logic              rxValid,
  output logic              rxErr
);
  // Transmit state
  logic [B_BITS-1:0] capB1, capB2;
  logic [D_BITS-1:0] capD;
  logic              txLastPol;   // 1 = +1, 0 = -1
  logic              txParity;    // odd marks in current group
  slot_t             txSlot;
  logic              txBit, txMark, txPol;

  // Receive state
  logic [B_BITS-1:0] accB1, accB2;
  logic [D_BITS-1:0] accD;
  logic              rxLastPol, rxSeenMark;
  logic              rxMark, rxPolIn;
  slot_t             rxSlot;

  always_comb begin
    txSlot = slotOf(txPos);
    unique case (txSlot.kind)
      SLOT_FRAME: txBit = 1'b0;
      SLOT_BAL:   txBit = ~txParity;
      SLOT_B1:    txBit = capB1[txSlot.idx];
      SLOT_B2:    txBit = capB2[txSlot.idx];
      SLOT_D:     txBit = capD[txSlot.idx[1:0]];
      default:    txBit = 1'b1;
    endcase
    txMark = ~txBit;
    txPol  = (txSlot.kind == SLOT_FRAME) ? txLastPol : ~txLastPol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capB1       <= '0;
      capB2       <= '0;
      capD        <= '0;
      txLastPol   <= 1'b0;
      txParity    <= 1'b0;
      txSym       <= SYM_ZERO;
      txFrameMark <= 1'b0;
    end else begin
      if (strobes.txFrame) begin
        capB1 <= txB1;
        capB2 <= txB2;
        capD  <= txD;
      end
      if (txMark) txLastPol <= txPol;
      if (txSlot.kind == SLOT_FRAME)    txParity <= 1'b1;
      else if (txSlot.kind == SLOT_BAL) txParity <= 1'b0;
      else                              txParity <= txParity ^ txMark;
      txSym       <= txMark ? (txPol ? SYM_POS : SYM_NEG) : SYM_ZERO;
      txFrameMark <= (txSlot.kind == SLOT_FRAME);
    end
  end

  always_comb begin
    rxMark  = (rxSym == SYM_POS) || (rxSym == SYM_NEG);
    rxPolIn = (rxSym == SYM_POS);
    rxViol  = rxMark && rxSeenMark && (rxPolIn == rxLastPol);
    rxSlot  = slotOf(rxPos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxLastPol  <= 1'b0;
      rxSeenMark <= 1'b0;
      accB1      <= '0;
      accB2      <= '0;
      accD       <= '0;
      rxB1       <= '0;
      rxB2       <= '0;
      rxD        <= '0;
      rxValid    <= 1'b0;
      rxErr      <= 1'b0;
    end else begin
      if (rxMark) begin
        rxLastPol  <= rxPolIn;
        rxSeenMark <= 1'b1;
      end
      unique case (rxSlot.kind)
        SLOT_B1: accB1[rxSlot.idx]      <= ~rxMark;
        SLOT_B2: accB2[rxSlot.idx]      <= ~rxMark;
        SLOT_D:  accD[rxSlot.idx[1:0]] <= ~rxMark;
        default: ;
      endcase
      rxErr   <= (rxSym == SYM_BAD);
      rxValid <= strobes.rxDeliver;
      if (strobes.rxDeliver) begin
        rxB1 <= accB1;
        rxB2 <= accB2;
        rxD  <= accD;
      end
    end
  end
endmodule

// File: rtl/bri_ternary_codec.sv
module bri_ternary_codec
  import bri_pkg::*;
#(
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 2,
  parameter int TX_OFFSET   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [B_BITS-1:0] txB1,
  input  logic [B_BITS-1:0] txB2,
  input  logic [D_BITS-1:0] txD,
  output logic [1:0]        txSym,
  output logic              txFrameMark,
  input  logic [1:0]        rxSym,
  output logic [B_BITS-1:0] rxB1,
  output logic [B_BITS-1:0] rxB2,
  output logic [D_BITS-1:0] rxD,
  output logic              rxValid,
  output logic              rxLock,
  output logic              rxErr
);
  logic [POS_W-1:0] txPos, rxPos;
  strobe_t          strobes;
  logic             rxViol;

  bri_codec_ctrl #(
    .LOCK_HITS  (LOCK_HITS),
    .LOSS_MISSES(LOSS_MISSES),
    .TX_OFFSET  (TX_OFFSET)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxViol (rxViol),
    .txPos  (txPos),
    .rxPos  (rxPos),
    .strobes(strobes),
    .rxLock (rxLock)
  );

  bri_codec_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .txB1       (txB1),
    .txB2       (txB2),
    .txD        (txD),
    .txPos      (txPos),
    .rxPos      (rxPos),
    .strobes    (strobes),
    .rxSym      (rxSym),
    .rxViol     (rxViol),
    .txSym      (txSym),
    .txFrameMark(txFrameMark),
    .rxB1       (rxB1),
    .rxB2       (rxB2),
    .rxD        (rxD),
    .rxValid    (rxValid),
    .rxErr      (rxErr)
  );
endmodule

// File: rtl/bri_codec_checker.sv
module bri_codec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] txSym,
  input logic       txFrameMark,
  input logic [1:0] rxSym,
  input logic       rxValid,
  input logic       rxLock,
  input logic       rxErr
);
  logic chkPol;  // polarity of the last transmitted mark, 1 = +1
  logic txIsMark;

  always_comb txIsMark = (txSym == 2'b01) || (txSym == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n)        chkPol <= 1'b0;
    else if (txIsMark) chkPol <= (txSym == 2'b01);
  end

  AST_TX_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    txSym != 2'b10); // R1
  AST_TX_MARK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (txIsMark && !txFrameMark) |-> ((txSym == 2'b01) != chkPol)); // R2
  AST_TX_FRAME_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    txFrameMark |-> (txIsMark && ((txSym == 2'b01) == chkPol))); // R3
  AST_LOCK_ON_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxLock) |-> ($past(rxSym) == 2'b01 || $past(rxSym) == 2'b11)); // R7
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> rxLock); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid); // R9
  AST_RX_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rxSym == 2'b10) |=> rxErr); // R10
endmodule

bind bri_ternary_codec bri_codec_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txSym      (txSym),
  .txFrameMark(txFrameMark),
  .rxSym      (rxSym),
  .rxValid    (rxValid),
  .rxLock     (rxLock),
  .rxErr      (rxErr)
);

// File: tb/bri_ternary_codec_bench.sv
module bri_ternary_codec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] txB1 = '0, txB2 = '0;
  logic [3:0]  txD = '0;
  logic [1:0]  rxSymDrv = 2'b00;
  logic [1:0]  txSym;
  logic        txFrameMark;
  logic [15:0] rxB1, rxB2;
  logic [3:0]  rxD;
  logic        rxValid, rxLock, rxErr;

  int nChecks = 0;
  int nFail = 0;
  logic [1:0] frameSyms [48];
  logic txModelPol = 1'b0;
  logic rxModelPol = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bri_ternary_codec u_bri_ternary_codec (
    .clk(clk), .rst_n(rst_n), .txB1(txB1), .txB2(txB2), .txD(txD),
    .txSym(txSym), .txFrameMark(txFrameMark), .rxSym(rxSymDrv),
    .rxB1(rxB1), .rxB2(rxB2), .rxD(rxD), .rxValid(rxValid),
    .rxLock(rxLock), .rxErr(rxErr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slot kinds: 0 frame, 1 balance, 2 bearer1, 3 bearer2, 4 signalling, 5 maintenance
  function automatic int kindOf(input int p);
    if (p == 0) return 0;
    if (p == 1 || p == 10 || p == 21 || p == 32 || p == 43 || p == 45) return 1;
    if ((p >= 2 && p <= 9) || (p >= 24 && p <= 31)) return 2;
    if ((p >= 13 && p <= 20) || (p >= 35 && p <= 42)) return 3;
    if (p == 11 || p == 22 || p == 33 || p == 44) return 4;
    return 5;
  endfunction

  function automatic int idxOf(input int p);
    if (p >= 2 && p <= 9)   return 17 - p;
    if (p >= 24 && p <= 31) return 31 - p;
    if (p >= 13 && p <= 20) return 28 - p;
    if (p >= 35 && p <= 42) return 42 - p;
    return (p - 11) / 11;
  endfunction

  function automatic logic [15:0] patB1(input int k);
    return 16'(k * 16'h1357 + k);
  endfunction
  function automatic logic [15:0] patB2(input int k);
    return ~16'(k * 16'h2468);
  endfunction
  function automatic logic [3:0] patD(input int k);
    return 4'(k * 5);
  endfunction

  task automatic encodeFrame(input logic [15:0] b1, input logic [15:0] b2,
                             input logic [3:0] d, inout logic pol);
    logic par;
    logic bitv;
    int   k;
    par = 1'b0;
    for (int p = 0; p < 48; p++) begin
      k = kindOf(p);
      case (k)
        0: bitv = 1'b0;
        1: bitv = ~par;
        2: bitv = b1[idxOf(p)];
        3: bitv = b2[idxOf(p)];
        4: bitv = d[idxOf(p)];
        default: bitv = 1'b1;
      endcase
      if (k == 0) begin
        frameSyms[p] = pol ? 2'b01 : 2'b11;
        par = 1'b1;
      end else if (!bitv) begin
        pol = ~pol;
        frameSyms[p] = pol ? 2'b01 : 2'b11;
        par = ~par;
      end else begin
        frameSyms[p] = 2'b00;
      end
      if (k == 1) par = 1'b0;
    end
  endtask

  task automatic sendSym(input logic [1:0] s);
    rxSymDrv = s;
    @(negedge clk);
  endtask

  task automatic sendFrame(input logic [15:0] b1, input logic [15:0] b2,
                           input logic [3:0] d, input bit idle,
                           input bit lockExp, input bit validExp, input bit alignExp);
    if (idle) begin
      for (int p = 0; p < 48; p++) frameSyms[p] = 2'b00;
    end else begin
      encodeFrame(b1, b2, d, rxModelPol);
    end
    for (int p = 0; p < 48; p++) begin
      sendSym(frameSyms[p]);
      if (p == 0) begin
        check(rxLock === lockExp, lockExp ? "R7,R8 lock held" : "R7,R8 lock low",
              64'(rxLock), 64'(lockExp));
        check(rxValid === 1'b0, "R9 no strobe at frame start", 64'(rxValid), 0);
      end
      if (p == 1 && alignExp)
        check(txFrameMark === 1'b1, "R11 tx frame two cycles after rx violation",
              64'(txFrameMark), 1);
      if (p == 47) begin
        if (validExp)
          check(rxValid === 1'b1 && rxB1 === b1 && rxB2 === b2 && rxD === d,
                "R9 delivered frame", {11'd0, rxValid, rxD, rxB2, rxB1},
                {11'd0, 1'b1, d, b2, b1});
        else
          check(rxValid === 1'b0, "R9 no delivery without lock", 64'(rxValid), 0);
      end
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    txB1 = patB1(0);
    txB2 = patB2(0);
    txD  = patD(0);
    repeat (3) @(negedge clk);
    // R12 reset state
    check(txSym === 2'b00 && txFrameMark === 1'b0, "R12 tx reset", 64'({txFrameMark, txSym}), 0);
    check(rxLock === 1'b0 && rxValid === 1'b0 && rxErr === 1'b0, "R12 rx reset",
          64'({rxLock, rxValid, rxErr}), 0);
    rst_n = 1'b1;

    // Transmit: four consecutive frames, inputs changed just after each capture
    for (int f = 0; f < 4; f++) begin
      while (txFrameMark !== 1'b1) @(negedge clk);
      encodeFrame(patB1(f), patB2(f), patD(f), txModelPol);
      for (int p = 0; p < 48; p++) begin
        int k;
        k = kindOf(p);
        check(txSym === frameSyms[p] && txFrameMark === (p == 0),
              (k == 0) ? "R1,R3 frame start" : (k == 1) ? "R5 balance" :
              (k == 5) ? "R2 maintenance" : "R2,R4,R6 data slot",
              64'({txFrameMark, txSym}), 64'({(p == 0), frameSyms[p]}));
        if (p == 0) begin
          txB1 = patB1(f + 1);
          txB2 = patB2(f + 1);
          txD  = patD(f + 1);
        end
        @(negedge clk);
      end
    end

    // Receive: opening mark, broken sequence, then lock
    repeat (3) sendSym(2'b00);
    sendSym(2'b01);
    rxModelPol = 1'b1;
    sendFrame(patB1(7), patB2(7), patD(7), 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(16'hFFFF, 16'hFFFF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);
    sendFrame(patB1(8), patB2(8), patD(8), 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(patB1(9), patB2(9), patD(9), 1'b0, 1'b0, 1'b0, 1'b0);
    sendFrame(patB1(10), patB2(10), patD(10), 1'b0, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++)
      sendFrame(patB1(k), patB2(k), patD(k), 1'b0, 1'b1, 1'b1, 1'b1);

    // Loss of lock: one miss tolerated, two in a row drop it
    sendFrame(16'hFFFF, 16'hFFFF, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0);
    sendFrame(patB1(11), patB2(11), patD(11), 1'b0, 1'b1, 1'b1, 1'b1);
    sendFrame(16'hFFFF, 16'hFFFF, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0);
    sendFrame(16'hFFFF, 16'hFFFF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);

    // Illegal symbol flag
    check(rxErr === 1'b0, "R10 no error on legal input", 64'(rxErr), 0);
    sendSym(2'b10);
    check(rxErr === 1'b1, "R10 error after illegal code", 64'(rxErr), 1);
    sendSym(2'b00);
    check(rxErr === 1'b0, "R10 error lasts one cycle", 64'(rxErr), 0);

    finishRun();
  end
endmodule